// File: doc/BRIEF.md
# Cluster Shared-Level Frequency Selector

This block picks one voltage/frequency operating point for a group of cores that share a single supply and clock. Each core supplies the minimum frequency it needs to meet its deadlines. The block finds the largest of these requests. It then chooses the lowest entry of an ascending table of operating points that covers that request. The whole cluster runs at that point, so the most demanding core sets the level for every core.

The choice is taken when the evaluate strobe is high and is held in registers until the next strobe. A regulator sequencer downstream therefore sees at most one change per evaluation. If no table entry is fast enough, the top entry is chosen and an infeasible flag is raised. Each core also gets its own sleep request, raised while its ready queue is empty. The other cores keep running.

Frequencies are unsigned integers in MHz, `FREQ_W` bits wide. Core `c` occupies bits `[c*FREQ_W +: FREQ_W]` of `demand_i`. Table entry `k` occupies bits `[k*FREQ_W +: FREQ_W]` of `table_i`. Entry 0 is the slowest.

Top module: `cluster_level_sel`

## Requirements
- R1: While reset is held low and after it is released, with no strobe yet, `level_o` = 0, `freq_o` = 0, `infeasible_o` = 0 and `sleep_o` = 0.
- R2: On the clock edge where `eval_i` is 1, `level_o` becomes the lowest index k whose table entry is >= the highest demand, including the case of exact equality. `freq_o` becomes that entry's value.
- R3: Only the largest demand affects the choice. Requests of 200, 400, 600 and 800 MHz, in any core order, select the 800 MHz entry.
- R4: If the highest demand is above every table entry, the strobe selects index `LEVELS-1` and its frequency, and sets `infeasible_o` to 1. A later strobe with a demand that can be met clears it.
- R5: If every demand is 0, the strobe selects index 0.
- R6: Without a strobe, `level_o`, `freq_o` and `infeasible_o` keep their values, whatever changes on `demand_i` or `table_i`.
- R7: `sleep_o[c]` becomes 1 one clock edge after `qempty_i[c]` rises. It stays 1 while `qempty_i[c]` stays 1, and it does not affect the other cores' bits.
- R8: `sleep_o[c]` returns to 0 in the same cycle that `qempty_i[c]` falls, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe; the selection is taken on this edge |
| demand_i | input | CORES*FREQ_W | Per-core minimum frequency requests, MHz |
| qempty_i | input | CORES | Per-core ready-queue-empty flags |
| table_i | input | LEVELS*FREQ_W | Operating-point frequencies, ascending, MHz |
| level_o | output | $clog2(LEVELS) | Selected table index |
| freq_o | output | FREQ_W | Frequency of the selected entry |
| infeasible_o | output | 1 | Highest demand exceeds the top entry |
| sleep_o | output | CORES | Per-core sleep requests |

## Verification
The level, frequency and infeasible flag are due one clock edge after the edge that samples `eval_i`. The bench raises the strobe at a falling edge, lowers it at the next falling edge, and reads the outputs at that moment. That is half a cycle after the register update. A sleep request is due one edge after its queue flag rises, and it is read at the following falling edge. Its release is combinational, so it is read a nanosecond after the flag drops, before any rising edge can intervene. Hold checks change the inputs over several cycles without a strobe and compare against the values captured earlier.

// File: rtl/cluster_level_pkg.sv
package cluster_level_pkg;
    localparam int DEF_CORES  = 4;
    localparam int DEF_LEVELS = 8;
    localparam int DEF_FREQ_W = 12;

    // result of the table search
    typedef enum logic { SEARCH_MISS = 1'b0, SEARCH_HIT = 1'b1 } search_res_e;
endpackage

// File: rtl/cluster_max_demand.sv
module cluster_max_demand #(
    parameter int CORES  = cluster_level_pkg::DEF_CORES,
    parameter int FREQ_W = cluster_level_pkg::DEF_FREQ_W
) (
    input  logic [CORES*FREQ_W-1:0] demand_i,
    output logic [FREQ_W-1:0]       max_o
);
    logic [FREQ_W-1:0] stage [CORES+1];

    assign stage[0] = '0;
    for (genvar c = 0; c < CORES; c++) begin : g_cmp
        logic [FREQ_W-1:0] cur;
        assign cur          = demand_i[c*FREQ_W +: FREQ_W];
        assign stage[c + 1] = (cur > stage[c]) ? cur : stage[c];
    end
    assign max_o = stage[CORES];
endmodule

// File: rtl/cluster_level_search.sv
module cluster_level_search
    import cluster_level_pkg::*;
#(
    parameter int LEVELS = DEF_LEVELS,
    parameter int FREQ_W = DEF_FREQ_W,
    localparam int LW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [LEVELS*FREQ_W-1:0] table_i,
    input  logic [FREQ_W-1:0]        need_i,
    output logic [LW-1:0]            idx_o,
    output logic [FREQ_W-1:0]        freq_o,
    output search_res_e              res_o
);
    // scan from the top down so the lowest satisfying entry wins
    always_comb begin
        idx_o  = LW'(LEVELS - 1);
        freq_o = table_i[(LEVELS-1)*FREQ_W +: FREQ_W];
        res_o  = SEARCH_MISS;
        for (int k = LEVELS - 1; k >= 0; k--) begin
            if (table_i[k*FREQ_W +: FREQ_W] >= need_i) begin
                idx_o  = LW'(k);
                freq_o = table_i[k*FREQ_W +: FREQ_W];
                res_o  = SEARCH_HIT;
            end
        end
    end
endmodule

// File: rtl/cluster_level_sel.sv
module cluster_level_sel
    import cluster_level_pkg::*;
#(
    parameter int CORES  = DEF_CORES,
    parameter int LEVELS = DEF_LEVELS,
    parameter int FREQ_W = DEF_FREQ_W,
    localparam int LW    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     eval_i,
    input  logic [CORES*FREQ_W-1:0]  demand_i,
    input  logic [CORES-1:0]         qempty_i,
    input  logic [LEVELS*FREQ_W-1:0] table_i,
    output logic [LW-1:0]            level_o,
    output logic [FREQ_W-1:0]        freq_o,
    output logic                     infeasible_o,
    output logic [CORES-1:0]         sleep_o
);
    typedef struct packed {
        logic [LW-1:0]     level;
        logic [FREQ_W-1:0] freq;
        logic              infeas;
        logic [CORES-1:0]  idle;
    } state_t;

    state_t state_d, state_q;

    logic [FREQ_W-1:0] peak_dem;
    logic [LW-1:0]     hit_idx;
    logic [FREQ_W-1:0] hit_freq;
    search_res_e       hit_res;

    cluster_max_demand #(.CORES(CORES), .FREQ_W(FREQ_W)) u_max (
        .demand_i (demand_i),
        .max_o    (peak_dem)
    );

    cluster_level_search #(.LEVELS(LEVELS), .FREQ_W(FREQ_W)) u_search (
        .table_i (table_i),
        .need_i  (peak_dem),
        .idx_o   (hit_idx),
        .freq_o  (hit_freq),
        .res_o   (hit_res)
    );

    always_comb begin
        state_d      = state_q;
        state_d.idle = qempty_i;
        if (eval_i) begin
            state_d.level  = hit_idx;
            state_d.freq   = hit_freq;
            state_d.infeas = (hit_res == SEARCH_MISS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign level_o      = state_q.level;
    assign freq_o       = state_q.freq;
    assign infeasible_o = state_q.infeas;
    // release follows the queue flag without waiting for an edge
    assign sleep_o      = state_q.idle & qempty_i;

    AST_HOLD_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> $stable({level_o, freq_o, infeasible_o})); // R6

    AST_MEETS_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> (infeasible_o || freq_o >= $past(peak_dem))); // R2

    AST_INFEAS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        infeasible_o |-> (level_o == LW'(LEVELS - 1))); // R4

    for (genvar c = 0; c < CORES; c++) begin : g_sleep_chk
        AST_SLEEP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            qempty_i[c] |=> (!qempty_i[c] || sleep_o[c])); // R7
    end
endmodule

// File: tb/cluster_level_sel_test.sv
module cluster_level_sel_test;
    localparam int CORES  = 4;
    localparam int LEVELS = 8;
    localparam int FREQ_W = 12;
    localparam int LW     = $clog2(LEVELS);

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     eval_i = 1'b0;
    logic [CORES*FREQ_W-1:0]  demand_i = '0;
    logic [CORES-1:0]         qempty_i = '0;
    logic [LEVELS*FREQ_W-1:0] table_i;
    logic [LW-1:0]            level_o;
    logic [FREQ_W-1:0]        freq_o;
    logic                     infeasible_o;
    logic [CORES-1:0]         sleep_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cluster_level_sel #(.CORES(CORES), .LEVELS(LEVELS), .FREQ_W(FREQ_W)) uut (
        .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .demand_i(demand_i),
        .qempty_i(qempty_i), .table_i(table_i), .level_o(level_o),
        .freq_o(freq_o), .infeasible_o(infeasible_o), .sleep_o(sleep_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_table();
        int f [LEVELS] = '{200, 400, 600, 800, 1000, 1200, 1600, 2000};
        for (int k = 0; k < LEVELS; k++) table_i[k*FREQ_W +: FREQ_W] = FREQ_W'(f[k]);
    endtask

    task automatic set_dem(input int d0, input int d1, input int d2, input int d3);
        demand_i[0*FREQ_W +: FREQ_W] = FREQ_W'(d0);
        demand_i[1*FREQ_W +: FREQ_W] = FREQ_W'(d1);
        demand_i[2*FREQ_W +: FREQ_W] = FREQ_W'(d2);
        demand_i[3*FREQ_W +: FREQ_W] = FREQ_W'(d3);
    endtask

    // strobe for one cycle; outputs read half a cycle after the capturing edge
    task automatic strobe();
        eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
    endtask

    task automatic expect_sel(input string req, input int lvl, input int f, input int inf);
        check(req, int'(level_o), lvl);
        check(req, int'(freq_o), f);
        check(req, int'(infeasible_o), inf);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_sel("R1", 0, 0, 0);
        check("R1", int'(sleep_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_sel("R1", 0, 0, 0);
        check("R1", int'(sleep_o), 0);
    endtask

    task automatic t_peak();
        set_dem(200, 400, 600, 800); strobe();
        expect_sel("R3", 3, 800, 0);
        set_dem(800, 600, 200, 400); strobe();
        expect_sel("R3", 3, 800, 0);
        set_dem(150, 0, 0, 90); strobe();
        expect_sel("R2", 0, 200, 0);
        set_dem(0, 401, 10, 300); strobe();
        expect_sel("R2", 2, 600, 0);
        set_dem(1200, 0, 1199, 0); strobe();   // exact equality
        expect_sel("R2", 5, 1200, 0);
        set_dem(0, 0, 0, 2000); strobe();
        expect_sel("R2", 7, 2000, 0);
    endtask

    task automatic t_zero();
        set_dem(0, 0, 0, 0); strobe();
        expect_sel("R5", 0, 200, 0);
    endtask

    task automatic t_infeasible();
        set_dem(100, 2001, 0, 0); strobe();
        expect_sel("R4", 7, 2000, 1);
        set_dem(100, 900, 0, 0); strobe();
        expect_sel("R4", 4, 1000, 0);
    endtask

    task automatic t_hold();
        set_dem(500, 0, 0, 0); strobe();
        expect_sel("R6", 2, 600, 0);
        for (int i = 0; i < 3; i++) begin
            set_dem(3000, 1700 + i, 0, 0);
            table_i[2*FREQ_W +: FREQ_W] = FREQ_W'(650 + i);
            @(negedge clk);
            expect_sel("R6", 2, 600, 0);
        end
        load_table();
    endtask

    task automatic t_sleep();
        qempty_i = 4'b0010;
        #1 check("R7", int'(sleep_o), 0);
        @(negedge clk);
        check("R7", int'(sleep_o), 2);
        qempty_i = 4'b1010;
        @(negedge clk);
        check("R7", int'(sleep_o), 10);
        set_dem(1500, 0, 0, 0); strobe();
        check("R7", int'(sleep_o), 10);
        expect_sel("R7", 6, 1600, 0);
        qempty_i = 4'b1000;
        #1 check("R8", int'(sleep_o), 8);
        @(negedge clk);
        qempty_i = 4'b0000;
        #1 check("R8", int'(sleep_o), 0);
        @(negedge clk);
        check("R8", int'(sleep_o), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        load_table();
        t_reset();
        t_peak();
        t_zero();
        t_infeasible();
        t_hold();
        t_sleep();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule